// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-visible face of a small address-translation unit. Software reaches it through a simple 32-bit register bus. Through this bus it sets the idle behaviour, turns translation, table walking and emulation-TLB mode on or off, and programs the translation table base. It also takes fault reports. The translation datapath raises one-cycle fault pulses, one per cause, together with the device address involved. The block latches these as sticky status bits, which software clears by writing ones. It drives a single interrupt line from the status bits that software has enabled.

A soft reset is started by a register write and completes on its own. A two-state machine governs it. In `ST_RUN` the block operates normally and the reset-done flag reads 1. A write that sets the soft-reset bit of the system configuration register takes the machine from `ST_RUN` to `ST_SOFT_RST`. There it counts `RST_CYCLES` clock cycles with reset-done reading 0, while every register returns to its default. When the count completes, the machine goes back to `ST_RUN`. Hardware reset enters `ST_RUN` directly.

Register offsets on the 8-bit byte address:
- revision 0x00
- system configuration 0x10
- system status 0x14
- interrupt status 0x18
- interrupt enable 0x1C
- walker status 0x40
- control 0x44
- fault address 0x48
- table base 0x4C

Top module: `xlat_ctl_regs`

## Requirements
- R1: The revision register at 0x00 reads 0x11, with the major version in bits 7:4 and the minor version in bits 3:0. Writes to it have no effect.
- R2: Writing a word with bit 1 set to 0x10 starts a soft reset. From the next cycle, bit 0 of 0x14 reads 0 for exactly 8 cycles (`RST_CYCLES`) and then reads 1. Bit 1 of 0x10 always reads 0.
- R3: While the soft reset runs, the following return to 0: system configuration, control, table base, interrupt enable, interrupt status and fault address. Bus writes and fault pulses are ignored during that time.
- R4: Bits 4:3 of 0x10 hold the idle mode (0 force, 1 none, 2 smart) and bit 0 holds auto-idle. Both read back and appear on `idle_mode` and `auto_idle`.
- R5: At 0x44, bit 1 drives `xlat_en`, bit 2 drives `walk_en` and bit 3 drives `emu_tlb_en`. Writing zeros to bits 3:1 turns all three off. Other bits read 0.
- R6: The table base at 0x4C keeps bits 31:14 of the written word, and bits 13:0 read 0. The stored value appears on `ttb_base`.
- R7: A pulse on `fault_pulse[k]` sets bit k of 0x18, whatever the enables are. The bits are: 0 TLB miss, 1 translation fault, 2 emulation miss, 3 table-walk fault, 4 multi-hit fault. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A pulse and a clear of the same bit in the same cycle leave the bit set.
- R8: `irq` is high exactly when some bit of 0x18 is set and the same bit of 0x1C is set. With 0x1C at 0x1E, a TLB miss alone leaves `irq` low.
- R9: 0x48 captures `fault_va` on a fault pulse of an enabled cause, but only when no enabled cause is already pending. Otherwise it holds its value.
- R10: Bit 0 of 0x40 reads `walk_busy`. Unmapped offsets read 0, and read-only registers ignore writes.
- R11: After hardware reset, every writable register is 0, 0x14 reads 1 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is in progress |
| fault_pulse | input | 5 | One-cycle fault events, one bit per cause |
| fault_va | input | 32 | Device address that goes with the fault pulse |
| walk_busy | input | 1 | Table walker activity, reported at 0x40 |
| irq | output | 1 | Interrupt request |
| xlat_en | output | 1 | Translation enable |
| walk_en | output | 1 | Table walker enable |
| emu_tlb_en | output | 1 | Emulation-TLB mode enable |
| ttb_base | output | 32 | Translation table base, 16 KiB aligned |
| idle_mode | output | 2 | Idle mode selection |
| auto_idle | output | 1 | Auto-idle enable |

## Verification
The fault logic is driven with several patterns:
- a lone TLB miss under the normal 0x1E mask, which separates the status bits from the interrupt line;
- an enabled fault arriving while another enabled fault is pending, which shows whether the fault address is overwritten or held;
- a zero write, a partial write-one and a write-one in the same cycle as a pulse of the same cause, which exercise each side of the clear-versus-set rule.

The soft reset is timed by polling the done flag, to show it lasts exactly the reset window. A control write and a fault pulse are issued inside that window, to show that both are dropped.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int NCAUSE = 5;

    typedef enum logic {ST_RUN, ST_SOFT_RST} srst_state_e;

    localparam logic [7:0] OFF_REV    = 8'h00;
    localparam logic [7:0] OFF_SYSCFG = 8'h10;
    localparam logic [7:0] OFF_SYSSTA = 8'h14;
    localparam logic [7:0] OFF_IRQST  = 8'h18;
    localparam logic [7:0] OFF_IRQEN  = 8'h1C;
    localparam logic [7:0] OFF_WALK   = 8'h40;
    localparam logic [7:0] OFF_CTRL   = 8'h44;
    localparam logic [7:0] OFF_FADDR  = 8'h48;
    localparam logic [7:0] OFF_TTB    = 8'h4C;

    localparam int SYSCFG_SRST_BIT = 1;
endpackage

// File: rtl/xlat_srst_fsm.sv
module xlat_srst_fsm #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    import xlat_pkg::*;

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

    srst_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        busy    = 1'b0;
        done    = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                if (start) begin
                    state_d = ST_SOFT_RST;
                    cnt_d   = '0;
                end
            end
            ST_SOFT_RST: begin
                busy = 1'b1;
                done = 1'b0;
                if (cnt_q == LAST) state_d = ST_RUN;
                else               cnt_d   = cnt_q + 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xlat_irq_unit.sv
module xlat_irq_unit #(
    parameter int NC = 5,
    parameter int VA_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_all,
    input  logic [NC-1:0] pulse,
    input  logic [VA_W-1:0] fault_va,
    input  logic          en_wr,
    input  logic [NC-1:0] en_wdata,
    input  logic [NC-1:0] st_clr,
    output logic [NC-1:0] irq_en,
    output logic [NC-1:0] irq_stat,
    output logic [VA_W-1:0] fault_addr,
    output logic          irq
);
    logic pending;
    logic capture;

    assign pending = |(irq_stat & irq_en);
    assign capture = !clear_all && |(pulse & irq_en) && !pending;
    assign irq     = pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en     <= '0;
            irq_stat   <= '0;
            fault_addr <= '0;
        end else if (clear_all) begin
            irq_en     <= '0;
            irq_stat   <= '0;
            fault_addr <= '0;
        end else begin
            if (en_wr) irq_en <= en_wdata;
            irq_stat <= (irq_stat & ~st_clr) | pulse;
            if (capture) fault_addr <= fault_va;
        end
    end
endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 8,
    parameter int TTB_ALIGN  = 14,
    parameter logic [3:0] REV_MAJOR = 4'd1,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [4:0]        fault_pulse,
    input  logic [DATA_W-1:0] fault_va,
    input  logic              walk_busy,
    output logic              irq,
    output logic              xlat_en,
    output logic              walk_en,
    output logic              emu_tlb_en,
    output logic [DATA_W-1:0] ttb_base,
    output logic [1:0]        idle_mode,
    output logic              auto_idle
);
    import xlat_pkg::*;

    localparam int NC = NCAUSE;

    logic srst_busy, reset_done;
    logic wr_ok;
    logic srst_start;
    logic [1:0] idle_q;
    logic       auto_q;
    logic [2:0] ctl_q;
    logic [DATA_W-1:TTB_ALIGN] ttb_q;
    logic [NC-1:0] irq_en, irq_stat, st_clr, pulse_ok;
    logic [DATA_W-1:0] fault_addr;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    assign wr_ok      = bus_en && bus_we && !srst_busy;
    assign srst_start = wr_ok && hit(bus_addr, OFF_SYSCFG) && bus_wdata[SYSCFG_SRST_BIT];
    assign st_clr     = (wr_ok && hit(bus_addr, OFF_IRQST)) ? bus_wdata[NC-1:0] : '0;
    assign pulse_ok   = srst_busy ? '0 : fault_pulse;

    xlat_srst_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (srst_busy),
        .done  (reset_done)
    );

    xlat_irq_unit #(.NC(NC), .VA_W(DATA_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (srst_busy),
        .pulse      (pulse_ok),
        .fault_va   (fault_va),
        .en_wr      (wr_ok && hit(bus_addr, OFF_IRQEN)),
        .en_wdata   (bus_wdata[NC-1:0]),
        .st_clr     (st_clr),
        .irq_en     (irq_en),
        .irq_stat   (irq_stat),
        .fault_addr (fault_addr),
        .irq        (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            auto_q <= 1'b0;
            ctl_q  <= '0;
            ttb_q  <= '0;
        end else if (srst_busy) begin
            idle_q <= '0;
            auto_q <= 1'b0;
            ctl_q  <= '0;
            ttb_q  <= '0;
        end else if (wr_ok) begin
            if (hit(bus_addr, OFF_SYSCFG)) begin
                idle_q <= bus_wdata[4:3];
                auto_q <= bus_wdata[0];
            end
            if (hit(bus_addr, OFF_CTRL)) ctl_q <= bus_wdata[3:1];
            if (hit(bus_addr, OFF_TTB))  ttb_q <= bus_wdata[DATA_W-1:TTB_ALIGN];
        end
    end

    assign xlat_en    = ctl_q[0];
    assign walk_en    = ctl_q[1];
    assign emu_tlb_en = ctl_q[2];
    assign ttb_base   = {ttb_q, {TTB_ALIGN{1'b0}}};
    assign idle_mode  = idle_q;
    assign auto_idle  = auto_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (ADDR_W'(bus_addr))
                ADDR_W'(OFF_REV):    bus_rdata = DATA_W'({REV_MAJOR, REV_MINOR});
                ADDR_W'(OFF_SYSCFG): bus_rdata = DATA_W'({idle_q, 2'b00, auto_q});
                ADDR_W'(OFF_SYSSTA): bus_rdata = DATA_W'(reset_done);
                ADDR_W'(OFF_IRQST):  bus_rdata = DATA_W'(irq_stat);
                ADDR_W'(OFF_IRQEN):  bus_rdata = DATA_W'(irq_en);
                ADDR_W'(OFF_WALK):   bus_rdata = DATA_W'(walk_busy);
                ADDR_W'(OFF_CTRL):   bus_rdata = DATA_W'({ctl_q, 1'b0});
                ADDR_W'(OFF_FADDR):  bus_rdata = fault_addr;
                ADDR_W'(OFF_TTB):    bus_rdata = ttb_base;
                default:             bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/xlat_ctl_regs_chk.sv
module xlat_ctl_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [4:0]        wlow,
    input logic [4:0]        fault_pulse,
    input logic              reset_done,
    input logic              srst_busy,
    input logic [4:0]        irq_stat,
    input logic [4:0]        irq_en,
    input logic [DATA_W-1:0] fault_addr,
    input logic              irq,
    input logic              xlat_en,
    input logic              walk_en,
    input logic              emu_tlb_en
);
    import xlat_pkg::*;

    logic wr;
    assign wr = bus_en && bus_we;

    assert_srst_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(OFF_SYSCFG) && wlow[1] && reset_done) |=> !reset_done);

    assert_srst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |=> (!xlat_en && !walk_en && !emu_tlb_en && irq_stat == '0));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_done && wr && bus_addr == ADDR_W'(OFF_IRQST) && fault_pulse == '0)
        |=> ((irq_stat & $past(wlow)) == '0));

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_done && |(fault_pulse & irq_en) && !(wr && bus_addr == ADDR_W'(OFF_IRQEN)))
        |=> irq);

    assert_faddr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_done && |(irq_stat & irq_en)) |=> $stable(fault_addr));
endmodule

bind xlat_ctl_regs xlat_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .wlow        (bus_wdata[4:0]),
    .fault_pulse (fault_pulse),
    .reset_done  (reset_done),
    .srst_busy   (srst_busy),
    .irq_stat    (irq_stat),
    .irq_en      (irq_en),
    .fault_addr  (fault_addr),
    .irq         (irq),
    .xlat_en     (xlat_en),
    .walk_en     (walk_en),
    .emu_tlb_en  (emu_tlb_en)
);

// File: tb/tb_xlat_ctl_regs.sv
`timescale 1ns/1ps
module tb_xlat_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  fault_pulse = '0;
    logic [31:0] fault_va = '0;
    logic        walk_busy = 1'b0;
    logic        irq, xlat_en, walk_en, emu_tlb_en, auto_idle;
    logic [31:0] ttb_base;
    logic [1:0]  idle_mode;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xlat_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fault_pulse(fault_pulse), .fault_va(fault_va), .walk_busy(walk_busy),
        .irq(irq), .xlat_en(xlat_en), .walk_en(walk_en), .emu_tlb_en(emu_tlb_en),
        .ttb_base(ttb_base), .idle_mode(idle_mode), .auto_idle(auto_idle)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse(input logic [4:0] m, input logic [31:0] va);
        @(negedge clk);
        fault_pulse = m; fault_va = va;
        @(negedge clk);
        fault_pulse = '0;
    endtask

    task automatic t_reset();
        rchk("R11 sysstatus", 8'h14, 32'h1);
        rchk("R11 sysconfig", 8'h10, 32'h0);
        rchk("R11 control", 8'h44, 32'h0);
        rchk("R11 ttb", 8'h4C, 32'h0);
        rchk("R11 irqstatus", 8'h18, 32'h0);
        check("R11 irq", {31'b0, irq}, 32'h0);
        rchk("R1 revision", 8'h00, 32'h11);
        wr(8'h00, 32'hFFFF_FFFF);
        rchk("R1 revision after write", 8'h00, 32'h11);
    endtask

    task automatic t_sysconfig();
        wr(8'h10, 32'h11);
        rchk("R4 sysconfig smart+auto", 8'h10, 32'h11);
        check("R4 idle_mode", {30'b0, idle_mode}, 32'h2);
        check("R4 auto_idle", {31'b0, auto_idle}, 32'h1);
        wr(8'h10, 32'h08);
        rchk("R4 sysconfig none", 8'h10, 32'h08);
        check("R4 idle_mode none", {30'b0, idle_mode}, 32'h1);
        rchk("R2 sysstatus untouched", 8'h14, 32'h1);
    endtask

    task automatic t_control();
        wr(8'h44, 32'hFFFF_FFFF);
        rchk("R5 control all", 8'h44, 32'hE);
        check("R5 enables", {29'b0, emu_tlb_en, walk_en, xlat_en}, 32'h7);
        wr(8'h44, 32'h4);
        check("R5 walk only", {29'b0, emu_tlb_en, walk_en, xlat_en}, 32'h2);
        wr(8'h44, 32'h0);
        check("R5 disabled", {29'b0, emu_tlb_en, walk_en, xlat_en}, 32'h0);
    endtask

    task automatic t_ttb();
        wr(8'h4C, 32'h1234_5678);
        rchk("R6 ttb read", 8'h4C, 32'h1234_4000);
        check("R6 ttb_base", ttb_base, 32'h1234_4000);
    endtask

    task automatic t_walk();
        walk_busy = 1;
        rchk("R10 walk busy", 8'h40, 32'h1);
        walk_busy = 0;
        rchk("R10 walk idle", 8'h40, 32'h0);
        rchk("R10 unmapped", 8'h24, 32'h0);
        wr(8'h14, 32'h0);
        rchk("R10 sysstatus read-only", 8'h14, 32'h1);
    endtask

    task automatic t_irq();
        wr(8'h1C, 32'h1E);
        rchk("R8 enable readback", 8'h1C, 32'h1E);
        pulse(5'h01, 32'hAAAA_0000);
        rchk("R7 tlb miss status", 8'h18, 32'h01);
        check("R8 tlb miss no irq", {31'b0, irq}, 32'h0);
        rchk("R9 no capture when disabled", 8'h48, 32'h0);
        wr(8'h18, 32'h01);
        rchk("R7 w1c", 8'h18, 32'h0);
        pulse(5'h02, 32'hBBBB_1000);
        check("R8 irq on translation fault", {31'b0, irq}, 32'h1);
        rchk("R9 capture", 8'h48, 32'hBBBB_1000);
        pulse(5'h08, 32'hCCCC_2000);
        rchk("R7 two pending", 8'h18, 32'h0A);
        rchk("R9 hold while pending", 8'h48, 32'hBBBB_1000);
        wr(8'h18, 32'h0);
        rchk("R7 write zero no effect", 8'h18, 32'h0A);
        wr(8'h18, 32'h02);
        rchk("R7 partial clear", 8'h18, 32'h08);
        check("R8 irq still", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h08);
        check("R8 irq drops", {31'b0, irq}, 32'h0);
        pulse(5'h10, 32'hDDDD_3000);
        rchk("R9 recapture", 8'h48, 32'hDDDD_3000);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 8'h18; bus_wdata = 32'h10;
        fault_pulse = 5'h10;
        @(negedge clk);
        bus_en = 0; bus_we = 0; fault_pulse = '0;
        rchk("R7 set beats clear", 8'h18, 32'h10);
        wr(8'h18, 32'h1F);
    endtask

    task automatic t_softreset();
        logic [31:0] d;
        int n;
        wr(8'h10, 32'h11);
        wr(8'h44, 32'hE);
        pulse(5'h04, 32'h0000_5000);
        wr(8'h10, 32'h13);
        rchk("R2 done low", 8'h14, 32'h0);
        n = 0;
        d = 0;
        while (d[0] == 1'b0 && n < 100) begin
            @(negedge clk);
            n++;
            rd(8'h14, d);
        end
        check("R2 reset length", n, 32'd8);
        rchk("R2 srst bit reads 0", 8'h10, 32'h0);
        rchk("R3 control default", 8'h44, 32'h0);
        rchk("R3 ttb default", 8'h4C, 32'h0);
        rchk("R3 enable default", 8'h1C, 32'h0);
        rchk("R3 status default", 8'h18, 32'h0);
        rchk("R3 faddr default", 8'h48, 32'h0);
        wr(8'h10, 32'h02);
        wr(8'h44, 32'hE);
        pulse(5'h1F, 32'h1111_1000);
        repeat (10) @(negedge clk);
        rchk("R3 write ignored", 8'h44, 32'h0);
        rchk("R3 pulse ignored", 8'h18, 32'h0);
        rchk("R2 done again", 8'h14, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sysconfig();
        t_control();
        t_ttb();
        t_walk();
        t_irq();
        t_softreset();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule